// File: doc/BRIEF.md
# Triggered Register Capture Engine

The engine stores a short program of capture instructions in an internal instruction memory and runs it when a trigger arrives. A trigger is either a write to the trigger register or a one-cycle pulse on the crash input. Each instruction turns into one or more transactions on a single-outstanding request/response bus master port. A select bit on every request chooses between two target buses: a fast bus and a slow bus. Words read by capture instructions are appended to an internal capture memory, which software reads back afterwards through an index port.

Four instruction kinds exist: a burst read of consecutive words, a single write, a masked read-modify-write, and a loop that reads a list of addresses a given number of times. Instructions are grouped into lists. Lists are enabled one after another, and each enabled list ends at the instruction word count present when it was enabled. A trigger runs every enabled list in order and then raises a done flag. While a run is in progress the block reports not-ready and ignores all configuration writes and triggers.

Top module: `cap_engine`

## Requirements
- R1: After reset, ready=1, done=0, cap_ovf=0, cap_count=0, no list is enabled and m_req=0.
- R2: An instruction starts with a header word: bits [31:30] give the kind (00 read, 01 write, 10 read-modify-write, 11 loop), bit 29 selects the bus and [15:0] holds a count. A read is the header followed by a start-address word. It captures count words, from the start address and each 4 bytes above, in order. A count of 0 means 1.
- R3: Header bit 29 = 0 drives m_sel=0 (the fast bus, the default when the bit is left clear). Bit 29 = 1 drives m_sel=1 (the slow bus).
- R4: A write is the header followed by an address word and a data word. It issues one bus write and captures nothing.
- R5: A read-modify-write is the header followed by address, value and mask words. It reads the address and then writes back (read & ~mask) | (value & mask). It captures nothing.
- R6: A loop header carries the iteration count in [15:0] (0 means 1) and the address count N in [23:16]. N address words follow. The whole address list is captured once per iteration, in list order.
- R7: Register 1 controls lists: wdata[31]=1 enables list wdata[7:0] and wdata[31]=0 disables it. An enable is taken only for the next list in order, and a disable only for the last enabled list. A trigger runs all enabled lists in order. A trigger with no list enabled is ignored.
- R8: A write of bit0=1 to register 2, or a one-cycle crash_trig pulse, starts a run while the block is idle. The run clears done, cap_count and cap_ovf, and done is set when the run finishes.
- R9: While a run is in progress, ready=0 and every configuration write and every trigger is ignored.
- R10: When the capture memory is full, further captured words are dropped and the sticky cap_ovf is set. cap_count never exceeds CAP_DEPTH.
- R11: A write of bit0=1 to register 3 while idle clears all instructions and lists, done, cap_ovf and cap_count.
- R12: While m_req is high and m_rsp has not arrived, m_addr, m_we, m_sel and m_wdata hold steady.
- R13: Register 0 appends one word to the instruction memory. Appends beyond the memory size are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_addr | input | 2 | Register: 0 append, 1 list control, 2 trigger, 3 config reset |
| cfg_wdata | input | 32 | Configuration write data |
| crash_trig | input | 1 | Crash trigger pulse |
| ready | output | 1 | High when configuration input is accepted |
| done | output | 1 | All enabled lists finished |
| cap_ovf | output | 1 | Sticky capture overflow |
| cap_count | output | $clog2(CAP_DEPTH+1) | Number of valid captured words |
| cap_rd_idx | input | $clog2(CAP_DEPTH) | Capture memory read index |
| cap_rd_data | output | 32 | Captured word at cap_rd_idx |
| m_req | output | 1 | Bus request |
| m_we | output | 1 | Bus write (1) or read (0) |
| m_sel | output | 1 | Bus select: 0 fast, 1 slow |
| m_addr | output | 32 | Bus byte address |
| m_wdata | output | 32 | Bus write data |
| m_rsp | input | 1 | Bus response, one cycle |
| m_rdata | input | 32 | Bus read data, valid with m_rsp |

## Verification
The bench builds the engine with INSN_DEPTH=16, CAP_DEPTH=8 and NLISTS=2. A ten-word burst therefore overruns the capture memory, so the drop-and-flag path can be reached with a short program. Two lists are enough to try out-of-order enables, the list boundary, and disabling the last list. A bus model that returns address-derived data, with a different mapping per bus, lets every captured word show both its address and the bus it came from.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_RMW   = 2'd2,
        OP_LOOP  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE, S_DECODE, S_RD, S_WR, S_RMW_RD, S_RMW_WR, S_LOOP
    } state_e;

    localparam logic [1:0] REG_APPEND = 2'd0;
    localparam logic [1:0] REG_LIST   = 2'd1;
    localparam logic [1:0] REG_TRIG   = 2'd2;
    localparam logic [1:0] REG_CLEAR  = 2'd3;
endpackage

// File: rtl/cap_insn_store.sv
module cap_insn_store #(
    parameter int DEPTH  = 32,
    parameter int NLISTS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         app_we,
    input  logic [31:0]                  app_data,
    input  logic                         list_we,
    input  logic                         list_on,
    input  logic [7:0]                   list_idx,
    input  logic [$clog2(DEPTH)-1:0]     rd_a_idx,
    input  logic [$clog2(DEPTH)-1:0]     rd_b_idx,
    input  logic [$clog2(DEPTH)-1:0]     rd_c_idx,
    output logic [31:0]                  rd_a,
    output logic [31:0]                  rd_b,
    output logic [31:0]                  rd_c,
    output logic [$clog2(DEPTH+1)-1:0]   limit,
    output logic                         any_en
);
    localparam int IW = $clog2(DEPTH);
    localparam int PW = $clog2(DEPTH + 1);
    localparam int LI = $clog2(NLISTS);
    localparam int LW = $clog2(NLISTS + 1);
    localparam logic [PW-1:0] DEPTH_P  = PW'(DEPTH);
    localparam logic [LW-1:0] NLISTS_P = LW'(NLISTS);

    typedef struct packed {
        logic [DEPTH-1:0][31:0]  mem;
        logic [PW-1:0]           wptr;
        logic [LW-1:0]           nen;
        logic [NLISTS-1:0][PW-1:0] ends;
    } store_t;

    store_t q, d;
    logic [LW-1:0] last_en;

    always_comb begin
        d       = q;
        last_en = q.nen - LW'(1);
        if (clr) begin
            d = '0;
        end else begin
            if (app_we && (q.wptr < DEPTH_P)) begin
                d.mem[q.wptr[IW-1:0]] = app_data;
                d.wptr = q.wptr + PW'(1);
            end
            if (list_we) begin
                if (list_on && (q.nen < NLISTS_P) && (list_idx == 8'(q.nen))) begin
                    d.ends[q.nen[LI-1:0]] = q.wptr;
                    d.nen = q.nen + LW'(1);
                end else if (!list_on && (q.nen != '0) && (list_idx == 8'(last_en))) begin
                    d.nen = last_en;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_a   = q.mem[rd_a_idx];
    assign rd_b   = q.mem[rd_b_idx];
    assign rd_c   = q.mem[rd_c_idx];
    assign any_en = (q.nen != '0);
    assign limit  = any_en ? q.ends[last_en[LI-1:0]] : '0;
endmodule

// File: rtl/cap_capture_buf.sv
module cap_capture_buf #(
    parameter int DEPTH = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        push,
    input  logic [31:0]                 push_data,
    input  logic [$clog2(DEPTH)-1:0]    rd_idx,
    output logic [31:0]                 rd_data,
    output logic [$clog2(DEPTH+1)-1:0]  count,
    output logic                        ovf
);
    localparam int IW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][31:0] mem;
        logic [CW-1:0]          cnt;
        logic                   ovf;
    } buf_t;

    buf_t q, d;

    always_comb begin
        d = q;
        if (clr) begin
            d.cnt = '0;
            d.ovf = 1'b0;
        end else if (push) begin
            if (q.cnt == FULL) begin
                d.ovf = 1'b1;
            end else begin
                d.mem[q.cnt[IW-1:0]] = push_data;
                d.cnt = q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data = q.mem[rd_idx];
    assign count   = q.cnt;
    assign ovf     = q.ovf;
endmodule

// File: rtl/cap_sequencer.sv
module cap_sequencer
    import cap_pkg::*;
#(
    parameter int IW = 5,
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          clr,
    input  logic [PW-1:0] limit,
    input  logic [31:0]   rd_a,
    input  logic [31:0]   rd_b,
    input  logic [31:0]   rd_c,
    output logic [IW-1:0] rd_a_idx,
    output logic [IW-1:0] rd_b_idx,
    output logic [IW-1:0] rd_c_idx,
    output logic          m_req,
    output logic          m_we,
    output logic          m_sel,
    output logic [31:0]   m_addr,
    output logic [31:0]   m_wdata,
    input  logic          m_rsp,
    input  logic [31:0]   m_rdata,
    output logic          push,
    output logic [31:0]   push_data,
    output logic          busy,
    output logic          done
);
    typedef struct packed {
        state_e        st;
        logic [PW-1:0] pc;
        logic [31:0]   op;
        logic [15:0]   cnt;
        logic [7:0]    ai;
        logic [31:0]   tmp;
        logic          done;
    } seq_t;

    seq_t q, d;
    logic [15:0]   reps;
    logic [PW-1:0] ia, ib, ic;

    always_comb begin
        d         = q;
        push      = 1'b0;
        push_data = m_rdata;
        m_req     = 1'b0;
        m_we      = 1'b0;
        m_sel     = q.op[29];
        m_addr    = rd_a;
        m_wdata   = rd_b;
        reps      = (q.op[15:0] == 16'd0) ? 16'd1 : q.op[15:0];
        ib        = q.pc + PW'(2);
        ic        = q.pc + PW'(3);
        case (q.st)
            S_DECODE: ia = q.pc;
            S_LOOP:   ia = q.pc + PW'(1) + PW'(q.ai);
            default:  ia = q.pc + PW'(1);
        endcase

        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.st   = S_DECODE;
                    d.pc   = '0;
                    d.done = 1'b0;
                end
            end
            S_DECODE: begin
                if (q.pc >= limit) begin
                    d.st   = S_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.op  = rd_a;
                    d.cnt = '0;
                    d.ai  = '0;
                    case (op_e'(rd_a[31:30]))
                        OP_READ:  d.st = S_RD;
                        OP_WRITE: d.st = S_WR;
                        OP_RMW:   d.st = S_RMW_RD;
                        default: begin
                            if (rd_a[23:16] == 8'd0) d.pc = q.pc + PW'(1);
                            else                     d.st = S_LOOP;
                        end
                    endcase
                end
            end
            S_RD: begin
                m_req  = 1'b1;
                m_addr = rd_a + {14'd0, q.cnt, 2'b00};
                if (m_rsp) begin
                    push = 1'b1;
                    if (q.cnt == reps - 16'd1) begin
                        d.pc = q.pc + PW'(2);
                        d.st = S_DECODE;
                    end else begin
                        d.cnt = q.cnt + 16'd1;
                    end
                end
            end
            S_WR: begin
                m_req = 1'b1;
                m_we  = 1'b1;
                if (m_rsp) begin
                    d.pc = q.pc + PW'(3);
                    d.st = S_DECODE;
                end
            end
            S_RMW_RD: begin
                m_req = 1'b1;
                if (m_rsp) begin
                    d.tmp = (m_rdata & ~rd_c) | (rd_b & rd_c);
                    d.st  = S_RMW_WR;
                end
            end
            S_RMW_WR: begin
                m_req   = 1'b1;
                m_we    = 1'b1;
                m_wdata = q.tmp;
                if (m_rsp) begin
                    d.pc = q.pc + PW'(4);
                    d.st = S_DECODE;
                end
            end
            S_LOOP: begin
                m_req = 1'b1;
                if (m_rsp) begin
                    push = 1'b1;
                    if (q.ai == q.op[23:16] - 8'd1) begin
                        d.ai = '0;
                        if (q.cnt == reps - 16'd1) begin
                            d.pc = q.pc + PW'(1) + PW'(q.op[23:16]);
                            d.st = S_DECODE;
                        end else begin
                            d.cnt = q.cnt + 16'd1;
                        end
                    end else begin
                        d.ai = q.ai + 8'd1;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase
        if (clr) d.done = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_a_idx = ia[IW-1:0];
    assign rd_b_idx = ib[IW-1:0];
    assign rd_c_idx = ic[IW-1:0];
    assign busy     = (q.st != S_IDLE);
    assign done     = q.done;
endmodule

// File: rtl/cap_engine.sv
module cap_engine
    import cap_pkg::*;
#(
    parameter int INSN_DEPTH = 32,
    parameter int CAP_DEPTH  = 64,
    parameter int NLISTS     = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [1:0]                      cfg_addr,
    input  logic [31:0]                     cfg_wdata,
    input  logic                            crash_trig,
    output logic                            ready,
    output logic                            done,
    output logic                            cap_ovf,
    output logic [$clog2(CAP_DEPTH+1)-1:0]  cap_count,
    input  logic [$clog2(CAP_DEPTH)-1:0]    cap_rd_idx,
    output logic [31:0]                     cap_rd_data,
    output logic                            m_req,
    output logic                            m_we,
    output logic                            m_sel,
    output logic [31:0]                     m_addr,
    output logic [31:0]                     m_wdata,
    input  logic                            m_rsp,
    input  logic [31:0]                     m_rdata
);
    localparam int IW = $clog2(INSN_DEPTH);
    localparam int PW = $clog2(INSN_DEPTH + 1);

    logic          busy, acc, app_we, list_we, clr, trig, start, any_en, push;
    logic [31:0]   rd_a, rd_b, rd_c, push_data;
    logic [IW-1:0] ia, ib, ic;
    logic [PW-1:0] limit;

    assign acc     = cfg_we && !busy;
    assign app_we  = acc && (cfg_addr == REG_APPEND);
    assign list_we = acc && (cfg_addr == REG_LIST);
    assign clr     = acc && (cfg_addr == REG_CLEAR) && cfg_wdata[0];
    assign trig    = (acc && (cfg_addr == REG_TRIG) && cfg_wdata[0]) || crash_trig;
    assign start   = trig && !busy && any_en;
    assign ready   = !busy;

    cap_insn_store #(.DEPTH(INSN_DEPTH), .NLISTS(NLISTS)) store_i (
        .clk, .rst_n, .clr, .app_we, .app_data(cfg_wdata),
        .list_we, .list_on(cfg_wdata[31]), .list_idx(cfg_wdata[7:0]),
        .rd_a_idx(ia), .rd_b_idx(ib), .rd_c_idx(ic),
        .rd_a, .rd_b, .rd_c, .limit, .any_en
    );

    cap_sequencer #(.IW(IW), .PW(PW)) seq_i (
        .clk, .rst_n, .start, .clr, .limit, .rd_a, .rd_b, .rd_c,
        .rd_a_idx(ia), .rd_b_idx(ib), .rd_c_idx(ic),
        .m_req, .m_we, .m_sel, .m_addr, .m_wdata, .m_rsp, .m_rdata,
        .push, .push_data, .busy, .done
    );

    cap_capture_buf #(.DEPTH(CAP_DEPTH)) buf_i (
        .clk, .rst_n, .clr(clr || start), .push, .push_data,
        .rd_idx(cap_rd_idx), .rd_data(cap_rd_data),
        .count(cap_count), .ovf(cap_ovf)
    );
endmodule

// File: rtl/cap_engine_chk.sv
module cap_engine_chk #(
    parameter int CAP_DEPTH = 64
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            ready,
    input logic                            done,
    input logic                            cap_ovf,
    input logic [$clog2(CAP_DEPTH+1)-1:0]  cap_count,
    input logic                            m_req,
    input logic                            m_we,
    input logic                            m_sel,
    input logic [31:0]                     m_addr,
    input logic [31:0]                     m_wdata,
    input logic                            m_rsp
);
    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_rsp) |=> (m_req && $stable(m_addr) && $stable(m_we)
                               && $stable(m_sel) && $stable(m_wdata)));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cap_count <= ($clog2(CAP_DEPTH+1))'(CAP_DEPTH));

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(!ready) && $past(cap_ovf)) |-> cap_ovf);

    assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(!ready)) |->
        (cap_count == $past(cap_count) || cap_count == $past(cap_count) + 1'b1));

    assert_bus_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> !ready);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ready);

    assert_we_in_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        m_we |-> m_req);
endmodule

bind cap_engine cap_engine_chk #(.CAP_DEPTH(CAP_DEPTH)) chk_i (.*);

// File: tb/cap_engine_tb_top.sv
module cap_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int INSN_DEPTH = 16;
    localparam int CAP_DEPTH  = 8;
    localparam int NLISTS     = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        crash_trig = 1'b0;
    logic        ready, done, cap_ovf;
    logic [3:0]  cap_count;
    logic [2:0]  cap_rd_idx = '0;
    logic [31:0] cap_rd_data;
    logic        m_req, m_we, m_sel;
    logic [31:0] m_addr, m_wdata;
    logic        m_rsp = 1'b0;
    logic [31:0] m_rdata = '0;

    int nchk = 0;
    int nfail = 0;
    int cycles = 0;

    logic [31:0] wl_addr [32];
    logic [31:0] wl_data [32];
    logic        wl_sel  [32];
    int          nwr = 0;
    logic        hold_err = 1'b0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    cap_engine #(.INSN_DEPTH(INSN_DEPTH), .CAP_DEPTH(CAP_DEPTH), .NLISTS(NLISTS)) dut_i (
        .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .crash_trig,
        .ready, .done, .cap_ovf, .cap_count, .cap_rd_idx, .cap_rd_data,
        .m_req, .m_we, .m_sel, .m_addr, .m_wdata, .m_rsp, .m_rdata
    );

    function automatic logic [31:0] tgt(input logic [31:0] a, input logic s);
        return s ? (a + 32'h0000_1000) : (a ^ 32'hA5A5_0000);
    endfunction

    function automatic logic [31:0] hdr(input logic [1:0] op, input logic s,
                                        input logic [7:0] n, input logic [15:0] c);
        return {op, s, 5'd0, n, c};
    endfunction

    // target bus model: one-cycle response to every request
    always @(negedge clk) begin
        if (!rst_n) begin
            m_rsp = 1'b0;
            pend  = 1'b0;
        end else if (m_req && !m_rsp) begin
            if (pend && (m_addr !== pend_addr)) hold_err = 1'b1;
            m_rsp   = 1'b1;
            m_rdata = tgt(m_addr, m_sel);
            pend    = 1'b0;
            if (m_we && nwr < 32) begin
                wl_addr[nwr] = m_addr;
                wl_data[nwr] = m_wdata;
                wl_sel[nwr]  = m_sel;
                nwr++;
            end
        end else begin
            m_rsp = 1'b0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            nfail++;
            $display("FAIL watchdog: run did not end act=%0d exp<=100000", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000; i++) begin
            if (done) break;
            @(negedge clk);
        end
    endtask

    task automatic run_sw();
        cfg(2'd2, 32'd1);
        wait_done();
    endtask

    task automatic cap_word(input int i, output logic [31:0] v);
        cap_rd_idx = 3'(i);
        #1;
        v = cap_rd_data;
    endtask

    task automatic t_reset();
        chk("R1 ready", 32'(ready), 32'd1);
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 ovf", 32'(cap_ovf), 32'd0);
        chk("R1 count", 32'(cap_count), 32'd0);
        chk("R1 req", 32'(m_req), 32'd0);
    endtask

    task automatic t_read_burst();
        logic [31:0] v;
        cfg(2'd3, 32'd1);
        cfg(2'd0, hdr(2'd0, 1'b0, 8'd0, 16'd3));
        cfg(2'd0, 32'h0000_0100);
        cfg(2'd1, 32'h8000_0000);
        run_sw();
        chk("R8 done after sw trigger", 32'(done), 32'd1);
        chk("R2 burst count", 32'(cap_count), 32'd3);
        for (int k = 0; k < 3; k++) begin
            cap_word(k, v);
            chk("R2/R3 burst word fast bus", v, tgt(32'h100 + 32'(4*k), 1'b0));
        end
    endtask

    task automatic t_read_slow();
        logic [31:0] v;
        cfg(2'd3, 32'd1);
        cfg(2'd0, hdr(2'd0, 1'b1, 8'd0, 16'd0));
        cfg(2'd0, 32'h0000_0200);
        cfg(2'd1, 32'h8000_0000);
        run_sw();
        chk("R2 count zero reads one", 32'(cap_count), 32'd1);
        cap_word(0, v);
        chk("R3 slow bus word", v, tgt(32'h200, 1'b1));
    endtask

    task automatic t_write_rmw();
        int base;
        logic [31:0] val, msk;
        val = 32'h1234_5678;
        msk = 32'hFF00_FF00;
        cfg(2'd3, 32'd1);
        cfg(2'd0, hdr(2'd1, 1'b0, 8'd0, 16'd0));
        cfg(2'd0, 32'h0000_0300);
        cfg(2'd0, 32'hDEAD_BEEF);
        cfg(2'd0, hdr(2'd2, 1'b1, 8'd0, 16'd0));
        cfg(2'd0, 32'h0000_0400);
        cfg(2'd0, val);
        cfg(2'd0, msk);
        cfg(2'd1, 32'h8000_0000);
        base = nwr;
        run_sw();
        chk("R4/R5 bus writes", 32'(nwr - base), 32'd2);
        chk("R4 write addr", wl_addr[base], 32'h300);
        chk("R4 write data", wl_data[base], 32'hDEAD_BEEF);
        chk("R3 write fast bus", 32'(wl_sel[base]), 32'd0);
        chk("R5 rmw addr", wl_addr[base+1], 32'h400);
        chk("R5 rmw data", wl_data[base+1], (tgt(32'h400, 1'b1) & ~msk) | (val & msk));
        chk("R3 rmw slow bus", 32'(wl_sel[base+1]), 32'd1);
        chk("R4/R5 nothing captured", 32'(cap_count), 32'd0);
    endtask

    task automatic t_loop();
        logic [31:0] v;
        logic [31:0] exp_a [4];
        exp_a = '{32'h500, 32'h600, 32'h500, 32'h600};
        cfg(2'd3, 32'd1);
        cfg(2'd0, hdr(2'd3, 1'b0, 8'd2, 16'd2));
        cfg(2'd0, 32'h0000_0500);
        cfg(2'd0, 32'h0000_0600);
        cfg(2'd1, 32'h8000_0000);
        run_sw();
        chk("R6 loop count", 32'(cap_count), 32'd4);
        for (int k = 0; k < 4; k++) begin
            cap_word(k, v);
            chk("R6 loop order", v, tgt(exp_a[k], 1'b0));
        end
    endtask

    task automatic t_lists();
        logic [31:0] v;
        cfg(2'd3, 32'd1);
        cfg(2'd0, hdr(2'd0, 1'b0, 8'd0, 16'd1));
        cfg(2'd0, 32'h0000_0700);
        cfg(2'd1, 32'h8000_0001);
        cfg(2'd2, 32'd1);
        repeat (20) @(negedge clk);
        chk("R7 out-of-order enable ignored, no run", 32'(done), 32'd0);
        chk("R7 out-of-order enable ignored, no capture", 32'(cap_count), 32'd0);
        cfg(2'd1, 32'h8000_0000);
        cfg(2'd0, hdr(2'd0, 1'b0, 8'd0, 16'd1));
        cfg(2'd0, 32'h0000_0800);
        cfg(2'd1, 32'h8000_0001);
        run_sw();
        chk("R7 two lists count", 32'(cap_count), 32'd2);
        cap_word(0, v);
        chk("R7 list 0 first", v, tgt(32'h700, 1'b0));
        cap_word(1, v);
        chk("R7 list 1 second", v, tgt(32'h800, 1'b0));
        cfg(2'd1, 32'h0000_0001);
        run_sw();
        chk("R7 disabled last list", 32'(cap_count), 32'd1);
    endtask

    task automatic t_busy();
        cfg(2'd3, 32'd1);
        cfg(2'd0, hdr(2'd0, 1'b0, 8'd0, 16'd6));
        cfg(2'd0, 32'h0000_0900);
        cfg(2'd1, 32'h8000_0000);
        cfg(2'd2, 32'd1);
        chk("R9 ready low while running", 32'(ready), 32'd0);
        cfg(2'd0, hdr(2'd0, 1'b0, 8'd0, 16'd1));
        cfg(2'd2, 32'd1);
        @(negedge clk); crash_trig = 1'b1;
        @(negedge clk); crash_trig = 1'b0;
        cfg(2'd3, 32'd1);
        wait_done();
        chk("R9 trigger while busy ignored", 32'(cap_count), 32'd6);
        chk("R9 reset while busy ignored", 32'(done), 32'd1);
        cfg(2'd1, 32'h8000_0001);
        run_sw();
        chk("R9/R13 append while busy ignored", 32'(cap_count), 32'd6);
    endtask

    task automatic t_ovf();
        logic [31:0] v;
        cfg(2'd3, 32'd1);
        cfg(2'd0, hdr(2'd0, 1'b0, 8'd0, 16'd10));
        cfg(2'd0, 32'h0000_0A00);
        cfg(2'd1, 32'h8000_0000);
        run_sw();
        chk("R10 count capped", 32'(cap_count), 32'd8);
        chk("R10 overflow flag", 32'(cap_ovf), 32'd1);
        cap_word(7, v);
        chk("R10 last kept word", v, tgt(32'hA1C, 1'b0));
    endtask

    task automatic t_clear();
        cfg(2'd3, 32'd1);
        chk("R11 ready", 32'(ready), 32'd1);
        chk("R11 done", 32'(done), 32'd0);
        chk("R11 ovf", 32'(cap_ovf), 32'd0);
        chk("R11 count", 32'(cap_count), 32'd0);
        @(negedge clk); crash_trig = 1'b1;
        @(negedge clk); crash_trig = 1'b0;
        repeat (20) @(negedge clk);
        chk("R11/R7 no lists after reset, trigger ignored", 32'(done), 32'd0);
    endtask

    task automatic t_crash();
        logic [31:0] v;
        cfg(2'd0, hdr(2'd0, 1'b1, 8'd0, 16'd2));
        cfg(2'd0, 32'h0000_0B00);
        cfg(2'd1, 32'h8000_0000);
        @(negedge clk); crash_trig = 1'b1;
        @(negedge clk); crash_trig = 1'b0;
        wait_done();
        chk("R8 crash trigger done", 32'(done), 32'd1);
        chk("R8 crash trigger count", 32'(cap_count), 32'd2);
        cap_word(1, v);
        chk("R8 crash trigger data", v, tgt(32'hB04, 1'b1));
    endtask

    task automatic t_append_full();
        cfg(2'd3, 32'd1);
        for (int k = 0; k < INSN_DEPTH / 2; k++) begin
            cfg(2'd0, hdr(2'd0, 1'b0, 8'd0, 16'd1));
            cfg(2'd0, 32'h0000_0C00);
        end
        cfg(2'd0, hdr(2'd0, 1'b0, 8'd0, 16'd1));
        cfg(2'd0, 32'h0000_0D00);
        cfg(2'd1, 32'h8000_0000);
        run_sw();
        chk("R13 appends past full dropped", 32'(cap_count), 32'd8);
        chk("R13 full memory runs to capture limit", 32'(cap_ovf), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_burst();
        t_read_slow();
        t_write_rmw();
        t_loop();
        t_lists();
        t_busy();
        t_ovf();
        t_clear();
        t_crash();
        t_append_full();
        chk("R12 request held until response", 32'(hold_err), 32'd0);
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    // records the address of a request that has not yet been answered
    always @(posedge clk) begin
        if (m_req && !m_rsp) begin
            pend      <= 1'b1;
            pend_addr <= m_addr;
        end
    end
endmodule